// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO

This block is a first-in first-out buffer that joins two unrelated clock domains whose data paths differ in width. The producer pushes 16-bit words on its own clock. The consumer pulls 8-bit bytes on a second clock. Every stored word therefore yields two reads: the low byte first, then the high byte. Each side has its own status: the producer sees a full flag and a fill count in words, and the consumer sees an empty flag and a fill count in bytes.

The position counters are kept in binary and converted to reflected-binary (Gray) code in their home domain. They then pass through a four-stage synchronizer chain into the other domain. The consumer-side counter carries one extra low-order bit, which selects the byte lane inside the current word. Only its word-granular part is sent to the producer. As a result, a storage slot is released to the writer only after both of its bytes have been read. Because the synchronizer adds latency, each side may see a stale view of the other side's progress, and the flags err toward caution.

The block is built for a 20 ns write clock and a 10 ns read clock, but it does not depend on that ratio. Each domain has its own asynchronous active-low reset, which is released synchronously inside the block.

Top module: `mwf_fifo`

## Requirements
- R1: Bytes leave the read port in the order the words were written, with bits [7:0] of each word delivered before bits [15:8].
- R2: With no reads, the buffer accepts exactly 16 words. `wr_full` is high at the write edge after the 16th accepted write.
- R3: A write request presented while `wr_full` is high stores nothing and does not advance the write position. After the buffer drains, no trace of that word appears at the read port.
- R4: A read request presented while `rd_empty` is high does not change `rd_data` and does not change `rd_used`.
- R5: `rd_data` takes the new byte on the read-clock edge that accepts a read request, and holds its value on every edge without an accepted read.
- R6: `wr_used` (4 bits) reports the number of stored words modulo 16, as seen from the write domain. It therefore reads 0 whenever `wr_full` is high.
- R7: `rd_used` (5 bits) reports the number of unread bytes modulo 32, as seen from the read domain. It therefore reads 0 whenever `rd_empty` is high, and also when 32 bytes are waiting.
- R8: While either domain is held in reset and after release: `wr_full`=0, `wr_used`=0, `rd_empty`=1, `rd_used`=0.
- R9: The Gray-coded position sent from each domain changes by at most one bit per source-clock edge.
- R10: `rd_empty` stays high for at least two read-clock edges after the write that fills an empty buffer; it falls only after that word has crossed the synchronizer.
- R11: A word whose low byte has been read but whose high byte has not still counts as one stored word in `wr_used`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_req | input | 1 | Write request; accepted when `wr_full` is low |
| wr_data | input | 16 | Word to store |
| wr_full | output | 1 | Buffer full, registered in the write domain |
| wr_used | output | 4 | Stored words modulo 16, write-domain view |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_req | input | 1 | Read request; accepted when `rd_empty` is low |
| rd_data | output | 8 | Byte returned by the last accepted read |
| rd_empty | output | 1 | Buffer empty, registered in the read domain |
| rd_used | output | 5 | Unread bytes modulo 32, read-domain view |

## Verification
The bench fills the buffer and then pushes one more word. A design that stored that word, or that moved its write position anyway, would overwrite the oldest word and return a wrong byte at the end of the drain. A single word is read one half at a time to test slot release: a design that freed the slot after the low byte would drop `wr_used` too early. The bench probes the read port during the synchronizer delay; a design that compared against the unsynchronized pointer would clear `rd_empty` there. The count wrap-around at exactly 16 words and 32 bytes is also checked, as are reads attempted while empty. A design that guarded underflow badly would change `rd_data` or make the count go negative.

// File: rtl/mwf_rst_sync.sv
module mwf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];
endmodule

// File: rtl/mwf_gray_sync.sv
module mwf_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mwf_ram.sv
module mwf_ram #(
  parameter int WR_W  = 16,
  parameter int RD_W  = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(WR_W / RD_W)
) (
  input  logic            wclk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [WR_W-1:0] wdata,
  input  logic            rclk,
  input  logic            rrst_n,
  input  logic            re,
  input  logic [AW-1:0]   raddr,
  input  logic [SW-1:0]   rlane,
  output logic [RD_W-1:0] rdata
);
  logic [WR_W-1:0] mem [DEPTH];
  logic [WR_W-1:0] rword;
  logic [RD_W-1:0] rdata_d;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rword   = mem[raddr];
    rdata_d = rdata;
    if (re) rdata_d = rword[rlane*RD_W +: RD_W];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata <= '0;
    else         rdata <= rdata_d;
  end

  p_rdata_hold_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/mwf_fifo.sv
module mwf_fifo #(
  parameter int WR_W        = 16,
  parameter int RD_W        = 8,
  parameter int WR_DEPTH    = 16,
  parameter int SYNC_STAGES = 4,
  localparam int AW         = $clog2(WR_DEPTH),
  localparam int SW         = $clog2(WR_W / RD_W)
) (
  input  logic               wr_clk,
  input  logic               wr_rst_n,
  input  logic               wr_req,
  input  logic [WR_W-1:0]    wr_data,
  output logic               wr_full,
  output logic [AW-1:0]      wr_used,
  input  logic               rd_clk,
  input  logic               rd_rst_n,
  input  logic               rd_req,
  output logic [RD_W-1:0]    rd_data,
  output logic               rd_empty,
  output logic [AW+SW-1:0]   rd_used
);
  localparam int WP = AW + 1;
  localparam int RP = AW + SW + 1;

  function automatic logic [WP-1:0] to_gray(input logic [WP-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [WP-1:0] from_gray(input logic [WP-1:0] g);
    logic [WP-1:0] b;
    b[WP-1] = g[WP-1];
    for (int i = WP - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wrst_n, rrst_n;
  mwf_rst_sync u_wrst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(wrst_n));
  mwf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(rrst_n));

  // write domain
  logic [WP-1:0] wbin_q, wbin_d, wgray_q, rgray_w, rword_w, wfill_d;
  logic          wacc, wfull_d;
  logic [AW-1:0] wused_d;

  mwf_gray_sync #(.W(WP), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));

  always_comb begin
    wacc    = wr_req && !wr_full;
    rword_w = from_gray(rgray_w);
    wbin_d  = wbin_q + WP'(wacc);
    wfill_d = wbin_d - rword_w;
    wfull_d = (wfill_d == WP'(WR_DEPTH));
    wused_d = wfill_d[AW-1:0];
  end

  always_ff @(posedge wr_clk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      wr_full <= 1'b0;
      wr_used <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= to_gray(wbin_d);
      wr_full <= wfull_d;
      wr_used <= wused_d;
    end
  end

  // read domain
  logic [RP-1:0]      rbin_q, rbin_d, rfill_d;
  logic [WP-1:0]      rgray_q, wgray_r, wword_r;
  logic               racc, rempty_d;
  logic [AW+SW-1:0]   rused_d;

  mwf_gray_sync #(.W(WP), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));

  always_comb begin
    racc     = rd_req && !rd_empty;
    wword_r  = from_gray(wgray_r);
    rbin_d   = rbin_q + RP'(racc);
    rfill_d  = {wword_r, {SW{1'b0}}} - rbin_d;
    rempty_d = (rfill_d == '0);
    rused_d  = rfill_d[AW+SW-1:0];
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rd_empty <= 1'b1;
      rd_used  <= '0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= to_gray(rbin_d[RP-1:SW]);
      rd_empty <= rempty_d;
      rd_used  <= rused_d;
    end
  end

  mwf_ram #(.WR_W(WR_W), .RD_W(RD_W), .DEPTH(WR_DEPTH)) u_ram (
    .wclk(wr_clk), .we(wacc), .waddr(wbin_q[AW-1:0]), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rrst_n), .re(racc),
    .raddr(rbin_q[RP-2:SW]), .rlane(rbin_q[SW-1:0]), .rdata(rd_data));

  p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    (wr_full && wr_req) |=> (wbin_q == $past(wbin_q)));
  p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_empty && rd_req) |=> (rbin_q == $past(rbin_q)));
  p_wgray_step_r9: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  p_rgray_step_r9: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  p_full_count_r6: assert property (@(posedge wr_clk) disable iff (!wrst_n)
    wr_full |-> (wr_used == '0));
  p_empty_count_r7: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    rd_empty |-> (rd_used == '0));
endmodule

// File: tb/tb_mwf_fifo.sv
module tb_mwf_fifo;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n, rd_rst_n, wr_req, rd_req;
  logic [15:0] wr_data;
  logic        wr_full, rd_empty;
  logic [3:0]  wr_used;
  logic [7:0]  rd_data;
  logic [4:0]  rd_used;
  int          checks = 0, errors = 0;
  bit          done = 0;

  localparam logic [15:0] VEC [8] = '{16'h3412, 16'h7856, 16'hBC9A, 16'hF0DE,
                                      16'h00FF, 16'hFF00, 16'h8001, 16'h5AA5};

  always #10 wr_clk = ~wr_clk;
  always #5  rd_clk = ~rd_clk;

  mwf_fifo dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge wr_clk); wr_req = 1'b1; wr_data = w;
  endtask
  task automatic wr_idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge wr_clk); wr_req = 1'b0; end
  endtask
  task automatic rd_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask
  task automatic pop_check(input string tag, input logic [7:0] exp);
    @(negedge rd_clk); rd_req = 1'b1;
    @(negedge rd_clk); rd_req = 1'b0;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_rst_n = 0; rd_rst_n = 0; wr_req = 0; rd_req = 0; wr_data = '0;
    wr_idle(3);
    check("R8 full in reset", wr_full, 0);
    check("R8 empty in reset", rd_empty, 1);
    wr_rst_n = 1; rd_rst_n = 1;
    wr_idle(5);
    check("R8 wr_full", wr_full, 0);
    check("R8 wr_used", wr_used, 0);
    check("R8 rd_empty", rd_empty, 1);
    check("R8 rd_used", rd_used, 0);

    // table walk: write all words, then drain bytes low half first
    foreach (VEC[i]) push(VEC[i]);
    wr_idle(12);
    check("R6 wr_used 8 words", wr_used, 8);
    check("R7 rd_used 16 bytes", rd_used, 16);
    foreach (VEC[i]) begin
      pop_check("R1/R5/R9 low byte", VEC[i][7:0]);
      pop_check("R1/R5/R9 high byte", VEC[i][15:8]);
    end
    wr_idle(12);
    check("R7 drained rd_used", rd_used, 0);
    check("R6 drained wr_used", wr_used, 0);
    check("R4 empty after drain", rd_empty, 1);

    // underflow attempt: data and count untouched
    @(negedge rd_clk); rd_req = 1'b1;
    rd_wait(3); rd_req = 1'b0;
    rd_wait(2);
    check("R4 rd_data held", rd_data, VEC[7][15:8]);
    check("R4 rd_used held", rd_used, 0);
    check("R5 still empty", rd_empty, 1);

    // latency and half-read word
    push(16'hA55A); wr_idle(1);
    rd_wait(2);
    check("R10 empty during sync", rd_empty, 1);
    rd_wait(12);
    check("R10 empty cleared", rd_empty, 0);
    check("R7 two bytes", rd_used, 2);
    pop_check("R1 low of single", 8'h5A);
    wr_idle(12);
    check("R11 half-read word counted", wr_used, 1);
    check("R7 one byte left", rd_used, 1);
    pop_check("R1 high of single", 8'hA5);
    wr_idle(12);
    check("R11 slot released", wr_used, 0);
    check("R4 empty again", rd_empty, 1);

    // fill to capacity plus one rejected word
    for (int i = 0; i < 17; i++) push(16'h1000 + 16'(i * 16'h0101));
    wr_idle(1);
    check("R2 full after 16", wr_full, 1);
    check("R6 wr_used wraps", wr_used, 0);
    rd_wait(12);
    check("R7 rd_used wraps at 32", rd_used, 0);
    check("R7 not empty with 32", rd_empty, 0);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w;
      w = 16'h1000 + 16'(i * 16'h0101);
      pop_check("R2 low byte", w[7:0]);
      pop_check("R2 high byte", w[15:8]);
    end
    wr_idle(12);
    check("R3 extra word dropped", rd_empty, 1);
    check("R3 wr_full cleared", wr_full, 0);
    pop_check("R3 no stale data", 8'h10 + 8'h0F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule